// File: doc/BRIEF.md
# Byte-Wide Daisy-Chain Configuration Loader

This block loads a device's configuration memory from a shared byte bus. One whole byte is taken on each rising edge of the externally driven configuration clock (`clk`) when the bus marks it valid. The bytes are stored in parallel into a register-array memory of `FRAMES x BYTES_PER_FRAME` bytes and are never shifted bit by bit. Every device on the bus reads a six-byte header: a fill byte, a preamble byte, a 24-bit length count and a second fill byte. Frame bytes after the header are taken only while the select input is high and the memory still has room.

Several loaders can share one bus as a pseudo daisy chain. Each device's `pass_o` drives the `sel_i` of the next one. `pass_o` goes low once the device is armed and returns high when its memory is full, which hands the bus to the next device. The bus has no back-pressure: `bus_vld_i` qualifies the byte, and there is no ready signal because every device on the bus must sample the same byte on the same edge.

A fixed number of start-up clocks after the final byte, the device releases its open-drain-style done output, but only if no constant-field error was seen. The done outputs of all devices are wired-AND together. A device enables its user outputs once it sees the shared done line high, so the whole chain goes active together.

Top module: `cfgl_loader`

## Requirements
- R1: On every rising `clk` edge where a byte is accepted, all 8 bits of `bus_byte_i` are written to the next configuration memory address, starting at address 0. No byte is taken on an edge where `bus_vld_i` is low.
- R2: Once armed, the header is parsed in this order: fill byte 8'hFF, preamble byte 8'hF2, three length bytes (most significant first), then fill byte 8'hFF. The length appears on `hdr_len_o`. Parsing does not depend on `sel_i`.
- R3: If any byte other than 8'hF2 follows the first fill byte, the parser goes back to waiting for a fill byte.
- R4: After the header, a byte is stored only when `bus_vld_i` and `sel_i` are both high and the memory is not full. Any other byte leaves the memory contents unchanged.
- R5: After reset `pass_o` is 1. It goes to 0 on the edge at which the second `osc_tick_i` strobe is sampled with `init_i` high (`OSC_WAIT`=2). Bytes that arrive before that edge are ignored.
- R6: `pass_o` returns to 1 on the edge that writes the last memory address. The length count does not end or shorten the load.
- R7: The constant fields are checked: the first byte of each frame must equal `FRAME_HEAD`, the last byte of each frame must equal `FRAME_TAIL`, and the last header byte must equal 8'hFF. A mismatch sets `cfg_err_o` on that edge, and it stays set until reset.
- R8: `done_o` goes to 1 (released) on the `STARTUP_CLKS`-th (default 5) rising edge after the edge that wrote the last byte. If `cfg_err_o` is set, `done_o` stays 0.
- R9: `user_en_o` rises on the first edge at which `done_line_i` is high while `done_o` is 1, and then stays high.
- R10: A synchronous active-high `rst` returns the block to waiting for `init_i` and the fill byte, and clears `cfg_err_o`, `done_o` and `user_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, driven externally |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Init level; arming starts while it is high |
| osc_tick_i | input | 1 | One-cycle strobe standing in for the internal oscillator |
| sel_i | input | 1 | Chip select; gates the acceptance of frame data |
| bus_vld_i | input | 1 | Marks the byte on the bus as valid this edge |
| bus_byte_i | input | 8 | Shared configuration byte bus |
| rd_addr_i | input | ADDR_W | Configuration memory read address |
| rd_data_o | output | 8 | Configuration memory contents at `rd_addr_i` |
| hdr_len_o | output | 24 | Length count taken from the header |
| pass_o | output | 1 | Chain output; high hands the bus to the next device |
| cfg_err_o | output | 1 | Sticky constant-field error flag |
| done_o | output | 1 | Open-drain done model: 0 pulls low, 1 releases |
| done_line_i | input | 1 | Level of the wired-AND done line |
| user_en_o | output | 1 | User outputs enabled |

## Verification
The bench builds the loader with `FRAMES`=2 and `BYTES_PER_FRAME`=3. With a six-byte memory, the table walk fills the memory completely and then drives one more byte into the full memory, so the handoff on `pass_o` and the refusal after full are both exercised. Frame head 8'h3C, frame tail 8'hC3 and the default five start-up clocks are kept, so the start-up window can be counted edge by edge. The small memory also lets short directed runs place a bad tail, a bad head and a length count that differs from the memory size.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] PRE_BYTE  = 8'hF2;
  localparam int         LEN_BYTES = 3;

  typedef enum logic [2:0] {
    HS_FILL,
    HS_PRE,
    HS_LEN,
    HS_TAIL,
    HS_BODY
  } hdr_state_t;
endpackage

// File: rtl/cfgl_arm.sv
module cfgl_arm #(
  parameter int OSC_WAIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic osc_tick_i,
  output logic armed_o,
  output logic arm_pulse_o
);
  localparam int CW = $clog2(OSC_WAIT + 1);
  localparam logic [CW-1:0] LAST = CW'(OSC_WAIT - 1);

  logic [CW-1:0] tick_q;
  logic          armed_q;
  logic          tick_seen;

  assign tick_seen   = init_i && osc_tick_i && !armed_q;
  assign arm_pulse_o = tick_seen && (tick_q == LAST);
  assign armed_o     = armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      armed_q <= 1'b0;
    end else if (arm_pulse_o) begin
      armed_q <= 1'b1;
    end else if (tick_seen) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_hdr.sv
module cfgl_hdr
  import cfgl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        armed_i,
  input  logic        vld_i,
  input  logic [7:0]  byte_i,
  output logic        body_o,
  output logic        bad_o,
  output logic [23:0] len_o
);
  hdr_state_t st_q;
  logic [1:0] cnt_q;
  logic       take;

  assign take   = armed_i && vld_i;
  assign body_o = (st_q == HS_BODY);
  assign bad_o  = take && (st_q == HS_TAIL) && (byte_i != FILL_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= HS_FILL;
      cnt_q <= '0;
      len_o <= '0;
    end else if (take) begin
      case (st_q)
        HS_FILL: if (byte_i == FILL_BYTE) st_q <= HS_PRE;
        HS_PRE:  st_q <= (byte_i == PRE_BYTE) ? HS_LEN : HS_FILL;
        HS_LEN: begin
          len_o <= {len_o[15:0], byte_i};
          if (cnt_q == 2'(LEN_BYTES - 1)) begin
            cnt_q <= '0;
            st_q  <= HS_TAIL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        HS_TAIL: st_q <= HS_BODY;
        default: st_q <= HS_BODY;
      endcase
    end
  end
endmodule

// File: rtl/cfgl_frame.sv
module cfgl_frame #(
  parameter int         FRAMES          = 4,
  parameter int         BYTES_PER_FRAME = 8,
  parameter logic [7:0] FRAME_HEAD      = 8'h3C,
  parameter logic [7:0] FRAME_TAIL      = 8'hC3,
  localparam int        DEPTH           = FRAMES * BYTES_PER_FRAME,
  localparam int        ADDR_W          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              body_i,
  input  logic              vld_i,
  input  logic              sel_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              full_o,
  output logic              wr_last_o,
  output logic              bad_o
);
  localparam int POS_W = $clog2(BYTES_PER_FRAME);
  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(BYTES_PER_FRAME - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic [7:0]        mem_q [DEPTH];
  logic [ADDR_W-1:0] wr_addr_q;
  logic [POS_W-1:0]  pos_q;
  logic              full_q;
  logic              accept;
  logic              head_bad;
  logic              tail_bad;

  assign accept    = body_i && vld_i && sel_i && !full_q;
  assign wr_last_o = accept && (wr_addr_q == ADDR_LAST);
  assign head_bad  = (pos_q == '0) && (byte_i != FRAME_HEAD);
  assign tail_bad  = (pos_q == POS_LAST) && (byte_i != FRAME_TAIL);
  assign bad_o     = accept && (head_bad || tail_bad);
  assign full_o    = full_q;
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk) begin
    if (accept) mem_q[wr_addr_q] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr_q <= '0;
      pos_q     <= '0;
      full_q    <= 1'b0;
    end else if (accept) begin
      wr_addr_q <= wr_addr_q + 1'b1;
      pos_q     <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      if (wr_last_o) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_startup.sv
module cfgl_startup #(
  parameter int STARTUP_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic full_i,
  input  logic err_i,
  input  logic done_line_i,
  output logic done_o,
  output logic user_en_o
);
  localparam int CW = $clog2(STARTUP_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          uen_q;

  assign done_o    = done_q;
  assign user_en_o = uen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      uen_q  <= 1'b0;
    end else begin
      if (full_i && !done_q) begin
        if (cnt_q == LAST) begin
          if (!err_i) done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (done_q && done_line_i) uen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_loader.sv
module cfgl_loader #(
  parameter int         FRAMES          = 4,
  parameter int         BYTES_PER_FRAME = 8,
  parameter logic [7:0] FRAME_HEAD      = 8'h3C,
  parameter logic [7:0] FRAME_TAIL      = 8'hC3,
  parameter int         STARTUP_CLKS    = 5,
  parameter int         OSC_WAIT        = 2,
  localparam int        ADDR_W          = $clog2(FRAMES * BYTES_PER_FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              osc_tick_i,
  input  logic              sel_i,
  input  logic              bus_vld_i,
  input  logic [7:0]        bus_byte_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [23:0]       hdr_len_o,
  output logic              pass_o,
  output logic              cfg_err_o,
  output logic              done_o,
  input  logic              done_line_i,
  output logic              user_en_o
);
  logic armed_w;
  logic arm_pulse_w;
  logic body_w;
  logic hdr_bad_w;
  logic full_w;
  logic wr_last_w;
  logic frm_bad_w;
  logic pass_q;
  logic err_q;

  cfgl_arm #(.OSC_WAIT(OSC_WAIT)) u_arm (
    .clk(clk), .rst(rst), .init_i(init_i), .osc_tick_i(osc_tick_i),
    .armed_o(armed_w), .arm_pulse_o(arm_pulse_w)
  );

  cfgl_hdr u_hdr (
    .clk(clk), .rst(rst), .armed_i(armed_w), .vld_i(bus_vld_i),
    .byte_i(bus_byte_i), .body_o(body_w), .bad_o(hdr_bad_w), .len_o(hdr_len_o)
  );

  cfgl_frame #(
    .FRAMES(FRAMES), .BYTES_PER_FRAME(BYTES_PER_FRAME),
    .FRAME_HEAD(FRAME_HEAD), .FRAME_TAIL(FRAME_TAIL)
  ) u_frame (
    .clk(clk), .rst(rst), .body_i(body_w), .vld_i(bus_vld_i), .sel_i(sel_i),
    .byte_i(bus_byte_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .full_o(full_w), .wr_last_o(wr_last_w), .bad_o(frm_bad_w)
  );

  cfgl_startup #(.STARTUP_CLKS(STARTUP_CLKS)) u_start (
    .clk(clk), .rst(rst), .full_i(full_w), .err_i(err_q),
    .done_line_i(done_line_i), .done_o(done_o), .user_en_o(user_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (arm_pulse_w) pass_q <= 1'b0;
      if (wr_last_w)   pass_q <= 1'b1;
      if (hdr_bad_w || frm_bad_w) err_q <= 1'b1;
    end
  end

  assign pass_o    = pass_q;
  assign cfg_err_o = err_q;
endmodule

// File: rtl/cfgl_loader_chk.sv
module cfgl_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        pass_o,
  input logic        cfg_err_o,
  input logic        done_o,
  input logic        user_en_o,
  input logic        done_line_i,
  input logic        full_w,
  input logic        armed_w,
  input logic        body_w,
  input logic [23:0] hdr_len_o
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> cfg_err_o); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    full_w |=> full_w); // R6
  AST_PASS_LOW_LOADING: assert property (@(posedge clk) disable iff (rst)
    (armed_w && !full_w) |-> !pass_o); // R5
  AST_PASS_HIGH_FULL: assert property (@(posedge clk) disable iff (rst)
    full_w |-> pass_o); // R6
  AST_DONE_CLEAN_FULL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (full_w && !cfg_err_o)); // R8
  AST_USER_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    user_en_o |-> done_o); // R9
  AST_USER_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    $rose(user_en_o) |-> $past(done_line_i)); // R9
  AST_LEN_FROZEN_BODY: assert property (@(posedge clk) disable iff (rst)
    body_w |=> $stable(hdr_len_o)); // R2
endmodule

bind cfgl_loader cfgl_loader_chk u_chk (
  .clk(clk), .rst(rst), .pass_o(pass_o), .cfg_err_o(cfg_err_o),
  .done_o(done_o), .user_en_o(user_en_o), .done_line_i(done_line_i),
  .full_w(full_w), .armed_w(armed_w), .body_w(body_w), .hdr_len_o(hdr_len_o)
);

// File: tb/test_cfgl_loader.sv
`timescale 1ns/100ps
module test_cfgl_loader;
  localparam int NV = 15;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_i = 1'b0, osc_tick_i = 1'b0, sel_i = 1'b0, bus_vld_i = 1'b0;
  logic [7:0] bus_byte_i = 8'h00;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [23:0] hdr_len_o;
  logic pass_o, cfg_err_o, done_o, user_en_o;
  logic other_done = 1'b0;
  logic done_line_i;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  assign done_line_i = done_o & other_done;

  always #2.5 clk = ~clk;

  cfgl_loader #(
    .FRAMES(2), .BYTES_PER_FRAME(3), .FRAME_HEAD(8'h3C), .FRAME_TAIL(8'hC3),
    .STARTUP_CLKS(5), .OSC_WAIT(2)
  ) i_cfgl_loader (
    .clk(clk), .rst(rst), .init_i(init_i), .osc_tick_i(osc_tick_i),
    .sel_i(sel_i), .bus_vld_i(bus_vld_i), .bus_byte_i(bus_byte_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .hdr_len_o(hdr_len_o),
    .pass_o(pass_o), .cfg_err_o(cfg_err_o), .done_o(done_o),
    .done_line_i(done_line_i), .user_en_o(user_en_o)
  );

  // {vld, sel, byte, expected pass_o, expected cfg_err_o}
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hF2, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h06, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'hFF, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h77, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h55, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h11, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hC3, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h3C, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h22, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hC3, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'h99, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input logic v, input logic s, input logic [7:0] b);
    bus_vld_i = v; sel_i = s; bus_byte_i = b;
    tick();
  endtask

  task automatic idle(input int n);
    bus_vld_i = 1'b0;
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; init_i = 1'b0; osc_tick_i = 1'b0; bus_vld_i = 1'b0;
    sel_i = 1'b0; other_done = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic do_arm();
    init_i = 1'b1;
    osc_tick_i = 1'b1; tick();
    osc_tick_i = 1'b0; tick();
    osc_tick_i = 1'b1; tick();
    osc_tick_i = 1'b0;
  endtask

  task automatic header(input logic [23:0] len);
    put(1'b1, 1'b0, 8'hFF); put(1'b1, 1'b0, 8'hF2);
    put(1'b1, 1'b0, len[23:16]); put(1'b1, 1'b0, len[15:8]);
    put(1'b1, 1'b0, len[7:0]); put(1'b1, 1'b0, 8'hFF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R10 pass after reset", pass_o, 1);
    chk("R10 done after reset", done_o, 0);
    chk("R10 user_en after reset", user_en_o, 0);
    chk("R10 err after reset", cfg_err_o, 0);

    // R5: arming
    init_i = 1'b1;
    osc_tick_i = 1'b1; tick(); osc_tick_i = 1'b0;
    chk("R5 pass after one tick", pass_o, 1);
    tick();
    osc_tick_i = 1'b1; tick(); osc_tick_i = 1'b0;
    chk("R5 pass after second tick", pass_o, 0);

    // R1 R2 R4 R6: table walk
    for (int i = 0; i < NV; i++) begin
      put(VEC[i][11], VEC[i][10], VEC[i][9:2]);
      chk($sformatf("R6 pass vec %0d", i), pass_o, VEC[i][1]);
      chk($sformatf("R7 err vec %0d", i), cfg_err_o, VEC[i][0]);
      if (i == 5) chk("R2 length unselected", hdr_len_o, 24'h6);
    end
    bus_vld_i = 1'b0;

    // R1 R4: memory readback
    begin
      logic [7:0] exp_mem [6] = '{8'h3C, 8'h11, 8'hC3, 8'h3C, 8'h22, 8'hC3};
      for (int a = 0; a < 6; a++) begin
        rd_addr_i = AW'(a); #0.5;
        chk($sformatf("R1 R4 mem %0d", a), rd_data_o, exp_mem[a]);
      end
    end

    // R8: one start-up edge already passed (last vector)
    idle(3);
    chk("R8 done after 4 edges", done_o, 0);
    idle(1);
    chk("R8 done after 5 edges", done_o, 1);
    idle(2);
    chk("R9 user_en line low", user_en_o, 0);
    other_done = 1'b1;
    idle(1);
    chk("R9 user_en line high", user_en_o, 1);

    // R3: preamble mismatch restarts header
    do_reset(); do_arm();
    put(1'b1, 1'b1, 8'hFF); put(1'b1, 1'b1, 8'hF1);
    header(24'h7);
    chk("R3 length after restart", hdr_len_o, 24'h7);
    chk("R3 no error", cfg_err_o, 0);

    // R5: bytes before arming ignored
    do_reset();
    put(1'b1, 1'b0, 8'hFF); put(1'b1, 1'b0, 8'hF2);
    do_arm();
    put(1'b1, 1'b0, 8'h00); put(1'b1, 1'b0, 8'h00); put(1'b1, 1'b0, 8'h09);
    chk("R5 pre-arm bytes ignored", hdr_len_o, 24'h0);

    // R7: bad trailing fill
    do_reset(); do_arm();
    put(1'b1, 1'b0, 8'hFF); put(1'b1, 1'b0, 8'hF2);
    put(1'b1, 1'b0, 8'h00); put(1'b1, 1'b0, 8'h00); put(1'b1, 1'b0, 8'h01);
    chk("R7 err before tail", cfg_err_o, 0);
    put(1'b1, 1'b0, 8'hFE);
    chk("R7 bad header tail", cfg_err_o, 1);

    // R6 R7 R8: short length, bad frame tail
    do_reset(); do_arm();
    header(24'h2);
    put(1'b1, 1'b1, 8'h3C); put(1'b1, 1'b1, 8'h11);
    chk("R7 err before bad tail", cfg_err_o, 0);
    put(1'b1, 1'b1, 8'hC4);
    chk("R7 bad frame tail", cfg_err_o, 1);
    chk("R6 length ignored", pass_o, 0);
    put(1'b1, 1'b1, 8'h3C); put(1'b1, 1'b1, 8'h22); put(1'b1, 1'b1, 8'hC3);
    chk("R6 pass at full", pass_o, 1);
    idle(8);
    chk("R8 done held by error", done_o, 0);
    do_reset();
    chk("R10 err cleared", cfg_err_o, 0);

    // R7: bad frame head
    do_arm();
    header(24'h6);
    put(1'b1, 1'b1, 8'h3D);
    chk("R7 bad frame head", cfg_err_o, 1);
    idle(1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule